// File: doc/BRIEF.md
# Triple-Voted Serial Configuration Bus Slave

This block is the remote end of a serial configuration link with one master and up to 32 slaves. The master sends frames on a clock/data pair. The clock pulses only while a frame is in flight. The slave oversamples both lines with its own system clock and builds 10-bit words from them. Each word is 2 control bits followed by 8 payload bits, sent most significant bit first. A frame that names this slave's strapped 5-bit address is turned into 16-bit register writes or reads on a local parallel bus with an 8-bit address. No acknowledge bit is ever exchanged.

Read results, and interrupt notices raised by local logic, go back to the master on a separate upstream clock/data pair. That pair is clocked only while a reply is being shifted out. The control state machine is one-hot. Each state flip-flop is held in three copies and resolved by a 2-of-3 vote, so a single upset in one copy has no effect. If the voted vector is ever not one-hot, the machine falls back to idle and drops the frame.

Top module: `scb_slave`

## Requirements
- R1: While `rst` is high and just after it is released, `up_clk`, `up_data`, `lb_we` and `lb_re` are all low.
- R2: A downstream bit is taken on each rising edge of `dn_clk`, most significant bit first, ten bits to a word. Control codes are 01 = header, 10 = data, 11 = end. If `IDLE_TICKS` system cycles pass with no `dn_clk` edge, the frame is closed and any partial word is discarded, so the next frame decodes correctly.
- R3: In a header word, payload bits [7:3] carry the target address and bit [2] selects read (1) or write (0). A frame for another address causes no local bus access and no upstream activity.
- R4: In a write frame, the word after the header gives the register address. Each following pair of data words, high byte first, produces one single-cycle `lb_we` pulse carrying that address and the 16-bit value. The address then increments, wrapping at 8 bits.
- R5: A trailing data word without a partner before the end word is dropped and writes nothing.
- R6: A read frame is header, address word, end word. It produces one single-cycle `lb_re` pulse, with `lb_rdata` valid during that cycle. The value is returned upstream as the word {10, high byte} followed by the word {11, low byte}.
- R7: `up_clk` is low when idle and toggles only while a reply is sent, with a period of 2*`HALF_PERIOD` cycles. `up_data` changes only while `up_clk` is low. Write frames cause no upstream activity.
- R8: A rising edge on `irq_in` is latched. Once the slave is idle, it sends exactly one upstream word {01, own address, 111}.
- R9: The one-hot control state is kept in three voted copies. Holding one copy at any value leaves the block's behaviour unchanged. A voted vector that is not one-hot returns the machine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the link bit rate |
| rst | input | 1 | Synchronous active-high reset |
| slave_addr | input | 5 | Strapped slave address |
| dn_clk | input | 1 | Downstream clock from master, active only during frames |
| dn_data | input | 1 | Downstream serial data |
| up_clk | output | 1 | Upstream clock to master, active only during replies |
| up_data | output | 1 | Upstream serial data |
| irq_in | input | 1 | Local interrupt request, rising edge sensitive |
| lb_addr | output | 8 | Local bus register address |
| lb_wdata | output | 16 | Local bus write data |
| lb_we | output | 1 | Local bus write strobe, one cycle |
| lb_re | output | 1 | Local bus read strobe, one cycle |
| lb_rdata | input | 16 | Local bus read data, valid while `lb_re` is high |

## Verification
The assertions assume that `dn_clk` is slow relative to `clk`: each level lasts many system cycles, and `dn_data` settles half a bit before the rising edge. They also assume the master leaves more than `IDLE_TICKS` cycles between frames and never talks over a reply in progress. The bench drives 10 MHz link timing from a 200 MHz clock with fixed half-periods. It waits longer than the timeout after each frame and for the full reply after each read. It raises `irq_in` only when no frame is on the wire.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int PAY_W  = 8;
  localparam int CT_W   = 2;
  localparam int WORD_W = CT_W + PAY_W;
  localparam int SA_W   = 5;
  localparam int DAT_W  = 2 * PAY_W;

  localparam logic [CT_W-1:0] CT_HDR = 2'b01;
  localparam logic [CT_W-1:0] CT_DAT = 2'b10;
  localparam logic [CT_W-1:0] CT_END = 2'b11;
  localparam logic [2:0]      IRQ_TAG = 3'b111;

  localparam int ST_N     = 8;
  localparam int ST_IDLE  = 0;
  localparam int ST_REGA  = 1;
  localparam int ST_WHI   = 2;
  localparam int ST_WLO   = 3;
  localparam int ST_RWAIT = 4;
  localparam int ST_RD    = 5;
  localparam int ST_REPLY = 6;
  localparam int ST_SKIP  = 7;

  typedef logic [ST_N-1:0] state_t;

  function automatic state_t st_vec(input int idx);
    return state_t'(1) << idx;
  endfunction
endpackage

// File: rtl/scb_tmr_reg.sv
module scb_tmr_reg #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_a, q_b, q_c;

  always_ff @(posedge clk) begin
    if (rst) q_a <= RST_VAL;
    else     q_a <= d;
  end

  always_ff @(posedge clk) begin
    if (rst) q_b <= RST_VAL;
    else     q_b <= d;
  end

  always_ff @(posedge clk) begin
    if (rst) q_c <= RST_VAL;
    else     q_c <= d;
  end

  assign q = (q_a & q_b) | (q_a & q_c) | (q_b & q_c);
endmodule

// File: rtl/scb_rx_deser.sv
module scb_rx_deser import scb_pkg::*; #(
  parameter int IDLE_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              frame_abort,
  output logic              frame_active
);
  localparam int TW = $clog2(IDLE_TICKS + 1);
  localparam int BW = $clog2(WORD_W);

  logic [2:0]        ck_s;
  logic [1:0]        dt_s;
  logic [WORD_W-2:0] shreg;
  logic [BW-1:0]     bitcnt;
  logic [TW-1:0]     idle_cnt;
  logic              rise;

  assign rise = ck_s[1] & ~ck_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_s <= '0;
      dt_s <= '0;
    end else begin
      ck_s <= {ck_s[1:0], sclk_in};
      dt_s <= {dt_s[0], sdata_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg        <= '0;
      bitcnt       <= '0;
      idle_cnt     <= '0;
      word         <= '0;
      word_vld     <= 1'b0;
      frame_abort  <= 1'b0;
      frame_active <= 1'b0;
    end else begin
      word_vld    <= 1'b0;
      frame_abort <= 1'b0;
      if (rise) begin
        frame_active <= 1'b1;
        idle_cnt     <= '0;
        shreg        <= {shreg[WORD_W-3:0], dt_s[1]};
        if (bitcnt == BW'(WORD_W - 1)) begin
          bitcnt   <= '0;
          word     <= {shreg, dt_s[1]};
          word_vld <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (frame_active) begin
        if (idle_cnt == TW'(IDLE_TICKS - 1)) begin
          frame_active <= 1'b0;
          frame_abort  <= 1'b1;
          bitcnt       <= '0;
          idle_cnt     <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scb_tx.sv
module scb_tx import scb_pkg::*; #(
  parameter int HALF_PERIOD = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                two_words,
  input  logic [2*WORD_W-1:0] load,
  output logic                sclk_out,
  output logic                sdata_out,
  output logic                busy
);
  localparam int DW = $clog2(HALF_PERIOD + 1);
  localparam int LW = $clog2(2 * WORD_W + 1);

  logic [2*WORD_W-1:0] shreg;
  logic [LW-1:0]       left;
  logic [DW-1:0]       div;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      left      <= '0;
      div       <= '0;
      busy      <= 1'b0;
      sclk_out  <= 1'b0;
      sdata_out <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        shreg     <= load;
        left      <= two_words ? LW'(2 * WORD_W) : LW'(WORD_W);
        div       <= '0;
        busy      <= 1'b1;
        sclk_out  <= 1'b0;
        sdata_out <= load[2*WORD_W-1];
      end
    end else if (div == DW'(HALF_PERIOD - 1)) begin
      div <= '0;
      if (!sclk_out) begin
        sclk_out <= 1'b1;
      end else begin
        sclk_out <= 1'b0;
        if (left == LW'(1)) begin
          busy      <= 1'b0;
          sdata_out <= 1'b0;
        end else begin
          shreg     <= shreg << 1;
          sdata_out <= shreg[2*WORD_W-2];
          left      <= left - 1'b1;
        end
      end
    end else begin
      div <= div + 1'b1;
    end
  end
endmodule

// File: rtl/scb_slave.sv
module scb_slave import scb_pkg::*; #(
  parameter int IDLE_TICKS  = 64,
  parameter int HALF_PERIOD = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SA_W-1:0]  slave_addr,
  input  logic             dn_clk,
  input  logic             dn_data,
  output logic             up_clk,
  output logic             up_data,
  input  logic             irq_in,
  output logic [PAY_W-1:0] lb_addr,
  output logic [DAT_W-1:0] lb_wdata,
  output logic             lb_we,
  output logic             lb_re,
  input  logic [DAT_W-1:0] lb_rdata
);
  logic              word_vld, frame_abort, frame_active;
  logic [WORD_W-1:0] word;
  logic [CT_W-1:0]   ctrl;
  logic [PAY_W-1:0]  pay;
  logic              hdr_match;

  state_t st, st_d;

  logic                rw_q;
  logic [PAY_W-1:0]    addr_q, hi_q;
  logic [DAT_W-1:0]    rd_q;
  logic [2:0]          irq_s;
  logic                irq_pend, irq_send, rd_go;
  logic                tx_start, tx_two, tx_busy;
  logic [2*WORD_W-1:0] tx_load;

  scb_rx_deser #(.IDLE_TICKS(IDLE_TICKS)) u_rx (
    .clk(clk), .rst(rst), .sclk_in(dn_clk), .sdata_in(dn_data),
    .word_vld(word_vld), .word(word), .frame_abort(frame_abort),
    .frame_active(frame_active)
  );

  assign ctrl      = word[WORD_W-1:PAY_W];
  assign pay       = word[PAY_W-1:0];
  assign hdr_match = (ctrl == CT_HDR) && (pay[PAY_W-1:PAY_W-SA_W] == slave_addr);
  assign rd_go     = !lb_re && !tx_busy && !tx_start;
  assign irq_send  = irq_pend && st[ST_IDLE] && !frame_active && !tx_busy && !tx_start;

  scb_tmr_reg #(.W(ST_N), .RST_VAL(state_t'(1))) u_state (
    .clk(clk), .rst(rst), .d(st_d), .q(st)
  );

  always_comb begin
    st_d = st;
    if ($countones(st) != 1) begin
      st_d = st_vec(ST_IDLE);
    end else if (frame_abort && !(st[ST_RD] || st[ST_REPLY])) begin
      st_d = st_vec(ST_IDLE);
    end else if (st[ST_RD]) begin
      if (rd_go) st_d = st_vec(ST_REPLY);
    end else if (st[ST_REPLY]) begin
      if (!tx_busy && !tx_start) st_d = st_vec(ST_IDLE);
    end else if (word_vld) begin
      if (ctrl == CT_END)
        st_d = st[ST_RWAIT] ? st_vec(ST_RD) : st_vec(ST_IDLE);
      else if (st[ST_IDLE])
        st_d = hdr_match ? st_vec(ST_REGA) : st_vec(ST_SKIP);
      else if (st[ST_REGA])
        st_d = (ctrl != CT_DAT) ? st_vec(ST_SKIP) :
               (rw_q ? st_vec(ST_RWAIT) : st_vec(ST_WHI));
      else if (st[ST_WHI])
        st_d = (ctrl == CT_DAT) ? st_vec(ST_WLO) : st_vec(ST_SKIP);
      else if (st[ST_WLO])
        st_d = (ctrl == CT_DAT) ? st_vec(ST_WHI) : st_vec(ST_SKIP);
      else if (st[ST_RWAIT])
        st_d = st_vec(ST_SKIP);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rw_q     <= 1'b0;
      addr_q   <= '0;
      hi_q     <= '0;
      rd_q     <= '0;
      lb_addr  <= '0;
      lb_wdata <= '0;
      lb_we    <= 1'b0;
      lb_re    <= 1'b0;
      irq_s    <= '0;
      irq_pend <= 1'b0;
      tx_start <= 1'b0;
      tx_two   <= 1'b0;
      tx_load  <= '0;
    end else begin
      lb_we    <= 1'b0;
      lb_re    <= 1'b0;
      tx_start <= 1'b0;
      irq_s    <= {irq_s[1:0], irq_in};
      if (lb_re) rd_q <= lb_rdata;
      if (word_vld && !frame_abort) begin
        if (st[ST_IDLE] && hdr_match) rw_q <= pay[PAY_W-SA_W-1];
        if (st[ST_REGA] && ctrl == CT_DAT) addr_q <= pay;
        if (st[ST_WHI] && ctrl == CT_DAT) hi_q <= pay;
        if (st[ST_WLO] && ctrl == CT_DAT) begin
          lb_we    <= 1'b1;
          lb_addr  <= addr_q;
          lb_wdata <= {hi_q, pay};
          addr_q   <= addr_q + 1'b1;
        end
        if (st[ST_RWAIT] && ctrl == CT_END) begin
          lb_re   <= 1'b1;
          lb_addr <= addr_q;
        end
      end
      if (st[ST_RD] && rd_go) begin
        tx_start <= 1'b1;
        tx_two   <= 1'b1;
        tx_load  <= {CT_DAT, rd_q[DAT_W-1:PAY_W], CT_END, rd_q[PAY_W-1:0]};
      end else if (irq_send) begin
        tx_start <= 1'b1;
        tx_two   <= 1'b0;
        tx_load  <= {CT_HDR, slave_addr, IRQ_TAG, {WORD_W{1'b0}}};
      end
      if (irq_s[1] && !irq_s[2]) irq_pend <= 1'b1;
      else if (irq_send)         irq_pend <= 1'b0;
    end
  end

  scb_tx #(.HALF_PERIOD(HALF_PERIOD)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .two_words(tx_two),
    .load(tx_load), .sclk_out(up_clk), .sdata_out(up_data), .busy(tx_busy)
  );
endmodule

// File: rtl/scb_slave_chk.sv
module scb_slave_chk import scb_pkg::*; (
  input logic   clk,
  input logic   rst,
  input state_t st,
  input logic   lb_we,
  input logic   lb_re,
  input logic   up_clk,
  input logic   up_data,
  input logic   tx_busy
);
  assert_state_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot(st));

  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    lb_we |=> !lb_we);

  assert_we_re_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(lb_we && lb_re));

  assert_re_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    lb_re |=> !lb_re);

  assert_up_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (up_clk && $past(up_clk)) |-> $stable(up_data));

  assert_up_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> !up_clk);
endmodule

bind scb_slave scb_slave_chk u_chk (
  .clk(clk), .rst(rst), .st(st), .lb_we(lb_we), .lb_re(lb_re),
  .up_clk(up_clk), .up_data(up_data), .tx_busy(tx_busy)
);

// File: tb/scb_slave_tb.sv
module scb_slave_tb;
  localparam int IDLE_T = 64;
  localparam int HALF   = 10;
  localparam logic [4:0] MY = 5'd9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dn_clk = 1'b0, dn_data = 1'b0, irq_in = 1'b0;
  logic up_clk, up_data, lb_we, lb_re;
  logic [7:0]  lb_addr;
  logic [15:0] lb_wdata, lb_rdata;

  always #2.5 clk = ~clk;

  scb_slave #(.IDLE_TICKS(IDLE_T), .HALF_PERIOD(HALF)) u_dut (
    .clk(clk), .rst(rst), .slave_addr(MY), .dn_clk(dn_clk), .dn_data(dn_data),
    .up_clk(up_clk), .up_data(up_data), .irq_in(irq_in), .lb_addr(lb_addr),
    .lb_wdata(lb_wdata), .lb_we(lb_we), .lb_re(lb_re), .lb_rdata(lb_rdata)
  );

  logic [15:0] dev_mem [0:255];
  logic [15:0] exp_mem [0:255];
  logic [7:0]  pl [0:7];
  int n_tests = 0, n_fail = 0, we_cnt = 0, up_cnt = 0;
  logic [19:0] up_shift = '0;

  function automatic logic [15:0] seedval(input int i);
    return 16'(i * 257) ^ 16'hA5C3;
  endfunction

  assign lb_rdata = dev_mem[lb_addr];

  always @(posedge clk) if (!rst && lb_we) begin
    dev_mem[lb_addr] = lb_wdata;
    we_cnt++;
  end

  always @(posedge up_clk) begin
    up_shift = {up_shift[18:0], up_data};
    up_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [9:0] w, input int n);
    for (int i = 9; i > 9 - n; i--) begin
      dn_data = w[i];
      repeat (HALF) @(negedge clk);
      dn_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      dn_clk = 1'b0;
    end
  endtask

  task automatic gap();
    repeat (IDLE_T + 30) @(negedge clk);
  endtask

  task automatic write_frame(input logic [4:0] sa, input logic [7:0] ra, input int nb);
    send_bits({2'b01, sa, 3'b000}, 10);
    send_bits({2'b10, ra}, 10);
    for (int i = 0; i < nb; i++) send_bits({2'b10, pl[i]}, 10);
    send_bits({2'b11, 8'h00}, 10);
    if (sa == MY)
      for (int k = 0; k < nb / 2; k++) exp_mem[8'(ra + k)] = {pl[2*k], pl[2*k+1]};
    gap();
  endtask

  task automatic read_frame(input logic [4:0] sa, input logic [7:0] ra,
                            output logic [19:0] got, output int nbits);
    up_cnt = 0;
    send_bits({2'b01, sa, 3'b100}, 10);
    send_bits({2'b10, ra}, 10);
    send_bits({2'b11, 8'h00}, 10);
    for (int t = 0; t < 800 && up_cnt < 20; t++) @(negedge clk);
    repeat (2 * HALF) @(negedge clk);
    got = up_shift;
    nbits = up_cnt;
    gap();
  endtask

  task automatic check_read(input string tag, input logic [7:0] ra);
    logic [19:0] got;
    int nb;
    read_frame(MY, ra, got, nb);
    chk(tag, 32'(got), 32'({2'b10, exp_mem[ra][15:8], 2'b11, exp_mem[ra][7:0]}));
    chk(tag, 32'(nb), 32'd20);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int w0, u0;
    logic [19:0] got;
    int nb;
    void'($urandom(32'd4321));
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = seedval(i);
      exp_mem[i] = seedval(i);
    end
    repeat (4) @(negedge clk);
    chk("R1 up_clk in reset", 32'(up_clk), 0);
    chk("R1 lb_we in reset", 32'(lb_we), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 up_data after reset", 32'(up_data), 0);
    chk("R1 lb_re after reset", 32'(lb_re), 0);

    // R4 R7: directed write of two registers, no upstream activity
    pl[0] = 8'hDE; pl[1] = 8'hAD; pl[2] = 8'hBE; pl[3] = 8'hEF;
    w0 = we_cnt; up_cnt = 0;
    write_frame(MY, 8'h10, 4);
    chk("R4 write count", 32'(we_cnt - w0), 2);
    chk("R4 reg 0x10", 32'(dev_mem[8'h10]), 32'h0000DEAD);
    chk("R4 reg 0x11 increment", 32'(dev_mem[8'h11]), 32'h0000BEEF);
    chk("R7 no upstream on write", 32'(up_cnt), 0);
    check_read("R6 read 0x11", 8'h11);
    // R4 address wrap
    pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'h56; pl[3] = 8'h78;
    write_frame(MY, 8'hFF, 4);
    chk("R4 wrap 0xFF", 32'(dev_mem[8'hFF]), 32'h00001234);
    chk("R4 wrap 0x00", 32'(dev_mem[8'h00]), 32'h00005678);

    // R3: other address ignored
    w0 = we_cnt; u0 = up_cnt;
    pl[0] = 8'h00; pl[1] = 8'h00;
    write_frame(5'd3, 8'h20, 2);
    chk("R3 foreign write count", 32'(we_cnt - w0), 0);
    chk("R3 foreign write mem", 32'(dev_mem[8'h20]), 32'(exp_mem[8'h20]));
    read_frame(5'd10, 8'h20, got, nb);
    chk("R3 foreign read silent", 32'(nb), 0);

    // R5: unpaired trailing word dropped
    w0 = we_cnt;
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
    write_frame(MY, 8'h30, 3);
    chk("R5 single write", 32'(we_cnt - w0), 1);
    chk("R5 next reg untouched", 32'(dev_mem[8'h31]), 32'(exp_mem[8'h31]));

    // R2: truncated frame then recovery
    w0 = we_cnt;
    send_bits({2'b01, MY, 3'b000}, 10);
    send_bits({2'b10, 8'h40}, 10);
    send_bits({2'b10, 8'h99}, 10);
    send_bits({2'b10, 8'h77}, 5);
    gap();
    chk("R2 truncated frame no write", 32'(we_cnt - w0), 0);
    pl[0] = 8'hC0; pl[1] = 8'hDE;
    write_frame(MY, 8'h41, 2);
    chk("R2 frame after timeout", 32'(dev_mem[8'h41]), 32'h0000C0DE);
    check_read("R2 read after timeout", 8'h41);

    // R8: interrupt word
    up_cnt = 0;
    irq_in = 1'b1;
    repeat (6) @(negedge clk);
    irq_in = 1'b0;
    for (int t = 0; t < 800 && up_cnt < 10; t++) @(negedge clk);
    repeat (300) @(negedge clk);
    chk("R8 irq word", 32'(up_shift[9:0]), 32'({2'b01, MY, 3'b111}));
    chk("R8 one word only", 32'(up_cnt), 10);

    // R9: one state copy held at a wrong value
    force u_dut.u_state.q_b = 8'h00;
    pl[0] = 8'h5A; pl[1] = 8'hA5;
    write_frame(MY, 8'h50, 2);
    chk("R9 write with upset copy", 32'(dev_mem[8'h50]), 32'h00005AA5);
    check_read("R9 read with upset copy", 8'h50);
    release u_dut.u_state.q_b;
    repeat (4) @(negedge clk);
    check_read("R9 read after release", 8'h10);

    // R4 R6: random bursts
    for (int it = 0; it < 8; it++) begin
      logic [7:0] ra;
      int np;
      ra = 8'($urandom);
      np = 1 + int'($urandom % 3);
      for (int i = 0; i < 2 * np; i++) pl[i] = 8'($urandom);
      if (($urandom % 3) == 0) begin
        w0 = we_cnt;
        write_frame(5'($urandom % 9), ra, 2 * np);
        chk("R3 random foreign", 32'(we_cnt - w0), 0);
      end else begin
        write_frame(MY, ra, 2 * np);
        for (int k = 0; k < np; k++) check_read("R6 random read", 8'(ra + k));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule